// File: doc/BRIEF.md
# Sleep and Wake-up Sequencer

This block decides when a small processor core enters its low-power sleep state and how it comes back out. The core's decoder raises a sleep strobe while it executes the sleep instruction. The sequencer samples that strobe in the last of the four clock phases of an instruction cycle. If no enabled interrupt source is pending at that point, it halts the core and clears a power-down status bit. If a source is pending, the instruction becomes a no-op: the core keeps running and the status bit is set, so software can tell that sleep was skipped.

While asleep, the block watches the gated interrupt sources. A wake event in a crystal-type oscillator mode first waits out a 1024-clock oscillator start-up interval. In every other mode, execution resumes at once. The instruction after the sleep then completes. If the global interrupt enable was 1 when the wake event was taken, the sequencer inserts one dummy instruction cycle and requests a fetch from the interrupt vector. Otherwise execution simply continues in-line.

Top module: `slp_wake_seq`

## Requirements
- R1: While `rst_n` is low, and after its synchronised release, `halt_o`, `redirect_o` and `dummy_o` are 0 and `pd_o` is 1. Asserting `rst_n` while the core is asleep clears the halt at once.
- R2: When `sleep_i` is sampled high at phase Q4 of a running cycle and no wake source is active, `halt_o` goes to 1 and `pd_o` to 0 on that edge. `pd_o` stays 0 through the following wake-up.
- R3: When `sleep_i` is sampled at Q4 while a wake source is active, the core is not halted and `pd_o` becomes 1.
- R4: A wake source is active when some `core_flag_i[k]` and `core_en_i[k]` are both 1. It is also active when `peri_gate_i` is 1 and some `peri_flag_i[k]` and `peri_en_i[k]` are both 1. A flag whose enable is 0, or a peripheral flag while `peri_gate_i` is 0, neither cancels sleep nor wakes the core.
- R5: In oscillator modes 0, 1 and 2 (`osc_mode_i` codes for the crystal types), `halt_o` falls on the 1025th rising edge, counting the edge that samples the wake source as the first.
- R6: In oscillator mode 3 (non-crystal), `halt_o` falls on the same edge that samples the wake source.
- R7: After `halt_o` falls, the sequencer spends one 4-clock instruction cycle with `dummy_o` at 0. If the interrupt enable was latched as 1, a 4-clock dummy cycle follows with `dummy_o` at 1. In the last clock of that dummy cycle, `redirect_o` is 1 and `vector_o` is 0x0004.
- R8: `gie_i` is latched on the edge that takes the wake event, and later changes of `gie_i` have no effect on that wake-up. If the latched value is 0, no dummy cycle and no redirect occur.
- R9: While `halt_o` is 1, `redirect_o` and `dummy_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock, one phase per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Sleep instruction strobe from the decoder |
| core_flag_i | input | NCORE | Core interrupt flags |
| core_en_i | input | NCORE | Individual enables for the core flags |
| peri_flag_i | input | NPERI | Peripheral interrupt flags |
| peri_en_i | input | NPERI | Individual enables for the peripheral flags |
| peri_gate_i | input | 1 | Group enable for the peripheral flags |
| gie_i | input | 1 | Global interrupt enable |
| osc_mode_i | input | 2 | 0..2 crystal types, 3 non-crystal |
| halt_o | output | 1 | Core halted |
| pd_o | output | 1 | Power-down status, 0 after a real sleep |
| redirect_o | output | 1 | Fetch-redirect request |
| vector_o | output | PC_W | Redirect address, valid with redirect_o |
| dummy_o | output | 1 | Current instruction cycle is a dummy cycle |

## Verification
The hardest situation to reach is a wake-up whose result depends on a value that changes after the wake edge: the enable must act as it was at that edge, while the start-up interval runs for over a thousand clocks. The stimulus flips `gie_i` right after the wake edge in every wake-up scenario. It then counts clocks until the halt clears and records the clock index of the first dummy cycle and of the redirect. A wrong latch, an off-by-one start-up count or a missing resume cycle each shows up as a count mismatch. A peripheral flag held behind a closed group gate, and a flag with its enable cleared, are used to show that neither can wake the core nor cancel sleep.

// File: rtl/sws_pkg.sv
package sws_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_OST    = 3'd2,
    ST_RESUME = 3'd3,
    ST_DUMMY  = 3'd4
  } sws_state_e;

  typedef enum logic [1:0] {
    OSC_LP  = 2'd0,
    OSC_XT  = 2'd1,
    OSC_HS  = 2'd2,
    OSC_INT = 2'd3
  } osc_mode_e;

  // Crystal-type sources need the start-up interval after wake-up.
  function automatic logic needs_startup(input logic [1:0] mode);
    return (osc_mode_e'(mode) != OSC_INT);
  endfunction

endpackage

// File: rtl/sws_rst_sync.sv
module sws_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[N-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[N-1];

endmodule

// File: rtl/sws_wake_src.sv
module sws_wake_src #(
  parameter int NCORE = 4,
  parameter int NPERI = 8
) (
  input  logic [NCORE-1:0] core_flag_i,
  input  logic [NCORE-1:0] core_en_i,
  input  logic [NPERI-1:0] peri_flag_i,
  input  logic [NPERI-1:0] peri_en_i,
  input  logic             peri_gate_i,
  output logic             wake_o
);

  logic [NCORE-1:0] core_hit;
  logic [NPERI-1:0] peri_hit;
  logic             peri_any;

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    assign core_hit[g] = core_flag_i[g] & core_en_i[g];
  end

  for (genvar g = 0; g < NPERI; g++) begin : g_peri
    assign peri_hit[g] = peri_flag_i[g] & peri_en_i[g];
  end

  assign peri_any = peri_gate_i & (|peri_hit);
  assign wake_o   = (|core_hit) | peri_any;

endmodule

// File: rtl/sws_phase.sv
module sws_phase #(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);

  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PHASES - 1);

  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_d;

  always_comb begin
    ph_d = ph_q;
    if (!run_i) begin
      ph_d = '0;
    end else if (ph_q == PH_LAST) begin
      ph_d = '0;
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign last_o = run_i && (ph_q == PH_LAST);

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (ph_q == '0));  // R7

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (ph_q == '0));  // R7

endmodule

// File: rtl/sws_ost.sv
module sws_ost #(
  parameter int OST_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);

  localparam logic [OST_W-1:0] CNT_MAX = '1;

  logic [OST_W-1:0] cnt_q;
  logic [OST_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = clr_i || en_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = en_i && !clr_i && (cnt_q == CNT_MAX);

  AST_OST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && !done_o) |=> (cnt_q == OST_W'($past(cnt_q) + 1'b1)));  // R5

  AST_OST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));  // R5

endmodule

// File: rtl/slp_wake_seq.sv
module slp_wake_seq
  import sws_pkg::*;
#(
  parameter int NCORE       = 4,
  parameter int NPERI       = 8,
  parameter int PC_W        = 13,
  parameter int VEC_ADDR    = 4,
  parameter int OST_W       = 10,
  parameter int PHASES      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic             sleep_i,
  input  logic [NCORE-1:0] core_flag_i,
  input  logic [NCORE-1:0] core_en_i,
  input  logic [NPERI-1:0] peri_flag_i,
  input  logic [NPERI-1:0] peri_en_i,
  input  logic             peri_gate_i,
  input  logic             gie_i,
  input  logic [1:0]       osc_mode_i,
  output logic             halt_o,
  output logic             pd_o,
  output logic             redirect_o,
  output logic [PC_W-1:0]  vector_o,
  output logic             dummy_o
);

  localparam logic [PC_W-1:0] VEC = PC_W'(VEC_ADDR);

  logic       srst_n;
  logic       wake_any;
  logic       q_last;
  logic       ost_done;
  logic       phase_run;
  logic       xtal;
  logic       sleep_take;

  sws_state_e state_q;
  sws_state_e state_d;
  logic       pd_q;
  logic       pd_d;
  logic       pd_en;
  logic       gie_q;
  logic       gie_en;

  sws_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk_osc),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sws_wake_src #(.NCORE(NCORE), .NPERI(NPERI)) u_wake (
    .core_flag_i (core_flag_i),
    .core_en_i   (core_en_i),
    .peri_flag_i (peri_flag_i),
    .peri_en_i   (peri_en_i),
    .peri_gate_i (peri_gate_i),
    .wake_o      (wake_any)
  );

  assign phase_run = (state_q == ST_RUN) || (state_q == ST_RESUME) ||
                     (state_q == ST_DUMMY);

  sws_phase #(.PHASES(PHASES)) u_phase (
    .clk    (clk_osc),
    .rst_n  (srst_n),
    .run_i  (phase_run),
    .last_o (q_last)
  );

  sws_ost #(.OST_W(OST_W)) u_ost (
    .clk    (clk_osc),
    .rst_n  (srst_n),
    .clr_i  (state_q != ST_OST),
    .en_i   (state_q == ST_OST),
    .done_o (ost_done)
  );

  assign xtal       = needs_startup(osc_mode_i);
  assign sleep_take = (state_q == ST_RUN) && q_last && sleep_i;

  // Next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (sleep_take && !wake_any) state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (wake_any) state_d = xtal ? ST_OST : ST_RESUME;
      end
      ST_OST: begin
        if (ost_done) state_d = ST_RESUME;
      end
      ST_RESUME: begin
        if (q_last) state_d = gie_q ? ST_DUMMY : ST_RUN;
      end
      ST_DUMMY: begin
        if (q_last) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  assign pd_en  = sleep_take;
  assign pd_d   = wake_any;
  assign gie_en = (state_q == ST_SLEEP) && wake_any;

  always_ff @(posedge clk_osc or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_osc or negedge srst_n) begin
    if (!srst_n) begin
      pd_q <= 1'b1;
    end else if (pd_en) begin
      pd_q <= pd_d;
    end
  end

  always_ff @(posedge clk_osc or negedge srst_n) begin
    if (!srst_n) begin
      gie_q <= 1'b0;
    end else if (gie_en) begin
      gie_q <= gie_i;
    end
  end

  assign halt_o     = (state_q == ST_SLEEP) || (state_q == ST_OST);
  assign pd_o       = pd_q;
  assign dummy_o    = (state_q == ST_DUMMY);
  assign redirect_o = (state_q == ST_DUMMY) && q_last;
  assign vector_o   = redirect_o ? VEC : '0;

  AST_SLEEP_ENTRY: assert property (@(posedge clk_osc) disable iff (!srst_n)
    (sleep_take && !wake_any) |=> (halt_o && !pd_o));  // R2

  AST_SLEEP_CANCEL: assert property (@(posedge clk_osc) disable iff (!srst_n)
    (sleep_take && wake_any) |=> (!halt_o && pd_o));  // R3

  AST_NO_STARTUP: assert property (@(posedge clk_osc) disable iff (!srst_n)
    ((state_q == ST_SLEEP) && wake_any && !xtal) |=> !halt_o);  // R6

  AST_HALT_QUIET: assert property (@(posedge clk_osc) disable iff (!srst_n)
    halt_o |-> (!redirect_o && !dummy_o));  // R9

  AST_REDIRECT_VEC: assert property (@(posedge clk_osc) disable iff (!srst_n)
    redirect_o |-> (dummy_o && gie_q && (vector_o == VEC)));  // R7

  AST_INLINE_RESUME: assert property (@(posedge clk_osc) disable iff (!srst_n)
    ((state_q == ST_RESUME) && q_last && !gie_q) |=> !dummy_o);  // R8

endmodule

// File: tb/tb_slp_wake_seq.sv
`timescale 1ns/1ps
module tb_slp_wake_seq;

  localparam int NCORE = 4;
  localparam int NPERI = 8;
  localparam int PC_W  = 13;
  localparam int WD_CYCLES = 150000;

  typedef struct packed {
    logic [1:0]  mode;
    logic        gie;
    logic        pend;
    logic        exp_sleep;
    logic [10:0] exp_wait;
    logic [2:0]  exp_dummy;
    logic        exp_redir;
  } vec_t;

  localparam vec_t [0:6] VECS = '{
    '{2'd0, 1'b1, 1'b0, 1'b1, 11'd1025, 3'd4, 1'b1},
    '{2'd3, 1'b0, 1'b0, 1'b1, 11'd1,    3'd0, 1'b0},
    '{2'd3, 1'b0, 1'b1, 1'b0, 11'd0,    3'd0, 1'b0},
    '{2'd1, 1'b0, 1'b0, 1'b1, 11'd1025, 3'd0, 1'b0},
    '{2'd3, 1'b1, 1'b0, 1'b1, 11'd1,    3'd4, 1'b1},
    '{2'd2, 1'b1, 1'b1, 1'b0, 11'd0,    3'd0, 1'b0},
    '{2'd2, 1'b1, 1'b0, 1'b1, 11'd1025, 3'd4, 1'b1}
  };

  logic             clk;
  logic             rst_n;
  logic             sleep_i;
  logic [NCORE-1:0] core_flag_i;
  logic [NCORE-1:0] core_en_i;
  logic [NPERI-1:0] peri_flag_i;
  logic [NPERI-1:0] peri_en_i;
  logic             peri_gate_i;
  logic             gie_i;
  logic [1:0]       osc_mode_i;
  logic             halt_o;
  logic             pd_o;
  logic             redirect_o;
  logic [PC_W-1:0]  vector_o;
  logic             dummy_o;

  int  nchk;
  int  nerr;
  logic done;

  slp_wake_seq #(.NCORE(NCORE), .NPERI(NPERI), .PC_W(PC_W)) dut (
    .clk_osc     (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .core_flag_i (core_flag_i),
    .core_en_i   (core_en_i),
    .peri_flag_i (peri_flag_i),
    .peri_en_i   (peri_en_i),
    .peri_gate_i (peri_gate_i),
    .gie_i       (gie_i),
    .osc_mode_i  (osc_mode_i),
    .halt_o      (halt_o),
    .pd_o        (pd_o),
    .redirect_o  (redirect_o),
    .vector_o    (vector_o),
    .dummy_o     (dummy_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue_sleep();
    sleep_i = 1'b1;
    repeat (4) step();
    sleep_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    done = 1'b0;
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYCLES);
      finish_run();
    end
  end

  initial begin
    int n;
    int bad;
    int fd;
    int rd;
    int dc;
    int rc;
    nchk = 0;
    nerr = 0;
    rst_n = 1'b0;
    sleep_i = 1'b0;
    core_flag_i = '0;
    core_en_i = '1;
    peri_flag_i = '0;
    peri_en_i = '0;
    peri_gate_i = 1'b0;
    gie_i = 1'b0;
    osc_mode_i = 2'd3;
    repeat (3) step();
    chk("R1", "halt in reset", int'(halt_o), 0);
    chk("R1", "pd in reset", int'(pd_o), 1);
    rst_n = 1'b1;
    repeat (5) step();
    chk("R1", "halt after reset", int'(halt_o), 0);
    chk("R1", "pd after reset", int'(pd_o), 1);
    chk("R1", "redirect after reset", int'(redirect_o), 0);
    chk("R1", "dummy after reset", int'(dummy_o), 0);

    // Table-driven scenarios
    for (int v = 0; v < 7; v++) begin
      core_en_i = '1;
      core_flag_i = '0;
      osc_mode_i = VECS[v].mode;
      gie_i = VECS[v].gie;
      core_flag_i[0] = VECS[v].pend;
      issue_sleep();
      core_flag_i[0] = 1'b0;
      if (VECS[v].exp_sleep) begin
        chk("R2", "halt after sleep", int'(halt_o), 1);
        chk("R2", "pd after sleep", int'(pd_o), 0);
        repeat (3) step();
        chk("R2", "still halted", int'(halt_o), 1);
        core_flag_i[1] = 1'b1;
        n = 0;
        bad = 0;
        do begin
          step();
          n++;
          if (n == 1) begin
            core_flag_i[1] = 1'b0;
            gie_i = ~gie_i;  // R8: change after the wake edge
          end
          if (halt_o && (dummy_o || redirect_o)) bad++;
        end while (halt_o && n < 3000);
        chk((VECS[v].mode == 2'd3) ? "R6" : "R5", "clocks to wake", n, int'(VECS[v].exp_wait));
        chk("R9", "fetch while halted", bad, 0);
        fd = -1;
        rd = -1;
        dc = 0;
        rc = 0;
        for (int i = 0; i < 12; i++) begin
          if (dummy_o) begin
            dc++;
            if (fd < 0) fd = i;
          end
          if (redirect_o) begin
            rc++;
            rd = i;
            chk("R7", "vector address", int'(vector_o), 4);
          end
          step();
        end
        chk(VECS[v].exp_dummy != 0 ? "R7" : "R8", "dummy clocks", dc, int'(VECS[v].exp_dummy));
        chk(VECS[v].exp_redir ? "R7" : "R8", "redirect pulses", rc, int'(VECS[v].exp_redir));
        if (VECS[v].exp_dummy != 0) begin
          chk("R7", "first dummy index", fd, 4);
          chk("R7", "redirect index", rd, 7);
        end
        chk("R2", "pd after wake", int'(pd_o), 0);
      end else begin
        chk("R3", "halt on cancelled sleep", int'(halt_o), 0);
        chk("R3", "pd on cancelled sleep", int'(pd_o), 1);
        repeat (4) step();
        chk("R3", "still running", int'(halt_o), 0);
      end
    end

    // R4: masked flag and closed peripheral gate
    osc_mode_i = 2'd3;
    gie_i = 1'b0;
    core_flag_i = '0;
    core_en_i = '1;
    core_en_i[2] = 1'b0;
    core_flag_i[2] = 1'b1;
    issue_sleep();
    chk("R4", "masked flag does not cancel", int'(halt_o), 1);
    chk("R4", "pd after masked sleep", int'(pd_o), 0);
    peri_en_i[0] = 1'b1;
    peri_flag_i[0] = 1'b1;
    repeat (20) step();
    chk("R4", "gated peripheral does not wake", int'(halt_o), 1);
    peri_gate_i = 1'b1;
    step();
    chk("R4", "open gate wakes", int'(halt_o), 0);
    peri_flag_i = '0;
    core_flag_i = '0;
    repeat (8) step();
    chk("R8", "no dummy with gie 0", int'(dummy_o), 0);

    // R1: reset while asleep
    issue_sleep();
    chk("R2", "halt before reset", int'(halt_o), 1);
    rst_n = 1'b0;
    #1;
    chk("R1", "reset clears halt", int'(halt_o), 0);
    chk("R1", "reset sets pd", int'(pd_o), 1);
    step();
    rst_n = 1'b1;
    repeat (5) step();
    chk("R1", "running after reset", int'(halt_o), 0);

    done = 1'b1;
    finish_run();
  end

endmodule